// File: doc/BRIEF.md
# Scanner Front-End Host Configuration Interface

This block is the host-facing control logic of a three-colour scanner front end. After power-on reset it works in one of two host modes, picked by the level of a shared strobe/enable pin during reset. In parallel mode the host uses strobed address and data cycles on an 8-bit slice of the shared output bus. In serial mode it shifts 16-bit frames over a three-wire link. Both modes reach the same register file, which holds one gain value and one offset value per colour, plus a control register.

The block also decides which colour (red, green or blue) the front end is working on. Two static select pins can set the colour directly. In auto-cycle mode, a line-start pulse on the first select pin steps the colour instead. The gain and offset values of the selected colour are presented continuously. A colour tag, delayed to match the four-cycle conversion pipeline, goes out alongside the conversion data. Conversion results enter as a 10-bit digital word and are placed on a three-state bus, given here as separate value and per-bit enable outputs. When the host reads in parallel mode, the configuration data takes over the bus.

Top module: `scan_host_ctrl`

## Requirements
- R1: The host mode is the value of `strb_sen` on the last clock edge at which `rst` is high: 1 gives parallel mode, 0 gives serial mode. The mode is held until the next reset.
- R2: In parallel mode, a high-to-low change of `strb_sen` while `rnw_sck`=0 performs a write. With `dna_sdi`=0 the write loads `bus_in` into the address pointer. With `dna_sdi`=1 it writes `bus_in` into the register the pointer names.
- R3: In parallel mode, while `strb_sen`=0 and `rnw_sck`=1, the bus drives on the same cycle. `bus_out[9:2]` carries the addressed register when `dna_sdi`=1, or the pointer when `dna_sdi`=0. `bus_out[1:0]`=0 and all `bus_oe` bits are 1.
- R4: In serial mode, each rising edge of `rnw_sck` while `strb_sen`=1 shifts `dna_sdi` in, MSB first. When `strb_sen` falls after exactly 16 bits, the frame commits as address (first 8 bits) and data (last 8 bits). A frame of any other length is dropped.
- R5: In serial mode, the bus is never driven with configuration data. `bus_oe` follows `oe_n` only.
- R6: Register map: 0x00, 0x01, 0x02 hold the 6-bit gains for red, green and blue. 0x04, 0x05, 0x06 hold the 8-bit offsets for red, green and blue. 0x08 bit 0 enables auto-cycle. All registers reset to 0. A write to any other address changes nothing, and a read of any other address returns 0. Unused upper bits read as 0.
- R7: With auto-cycle off, `colour_sel` takes its value from `{sel1, sel0_line}` one cycle after the pins are sampled. 00 gives red (0), 01 gives green (1), 10 gives blue (2), and 11 gives red (0). Reset sets red.
- R8: With auto-cycle on, each rising edge of `sel0_line` steps the colour red→green→blue→red, visible one cycle after the edge is sampled. Holding `sel0_line` high or changing `sel1` has no effect.
- R9: `gain_cur` and `offset_cur` always show the registers of the colour on `colour_sel` in the same cycle.
- R10: `colour_tag` equals the value `colour_sel` had 4 clock cycles earlier.
- R11: When no parallel read is active, `oe_n`=0 drives `bus_out`=`adc_data` with all enables set. `oe_n`=1 clears every bit of `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_sen | input | 1 | Parallel strobe (active low) / serial frame enable (active high); sampled in reset for mode |
| rnw_sck | input | 1 | Parallel read(1)/write(0) / serial clock |
| dna_sdi | input | 1 | Parallel data(1)/address(0) / serial data |
| bus_in | input | 8 | Input side of bus bits 9..2 |
| bus_out | output | 10 | Value driven on the bus |
| bus_oe | output | 10 | Per-bit drive enable of the bus |
| oe_n | input | 1 | Conversion output enable, active low |
| sel0_line | input | 1 | Colour select bit 0 / line-start pulse in auto-cycle mode |
| sel1 | input | 1 | Colour select bit 1 |
| adc_data | input | 10 | Conversion result |
| colour_sel | output | 2 | Current colour (0 red, 1 green, 2 blue) |
| colour_tag | output | 2 | Colour delayed by the conversion latency |
| gain_cur | output | 6 | Gain of the current colour |
| offset_cur | output | 8 | Offset of the current colour |

## Verification
Parallel read data and conversion data on the bus are combinational. They are checked two time units after the inputs change, within the same cycle. A parallel or serial write reaches its register two edges after the strobe or enable edge is sampled, so register contents are read back only after the transfer sequence has added extra idle cycles. A colour change shows up one edge after the select pins or the line-start edge are sampled, and the bench checks it at the following falling clock edge. The tag is compared against a history of `colour_sel` samples taken four cycles earlier.

// File: rtl/scan_host_pkg.sv
package scan_host_pkg;

    localparam int CFG_W   = 8;
    localparam int GAIN_W  = 6;
    localparam int OFF_W   = 8;
    localparam int NUM_COL = 3;
    localparam int SER_LEN = 2 * CFG_W;

    localparam logic [CFG_W-1:0] GAIN_BASE = 8'h00;
    localparam logic [CFG_W-1:0] OFFS_BASE = 8'h04;
    localparam logic [CFG_W-1:0] CTRL_ADDR = 8'h08;

    typedef enum logic [1:0] {
        COL_R = 2'd0,
        COL_G = 2'd1,
        COL_B = 2'd2
    } colour_e;

    typedef struct packed {
        logic             vld;
        logic [CFG_W-1:0] addr;
        logic [CFG_W-1:0] data;
    } wr_req_t;

    function automatic colour_e decode_sel(input logic s1, input logic s0);
        case ({s1, s0})
            2'b01:   return COL_G;
            2'b10:   return COL_B;
            default: return COL_R;
        endcase
    endfunction

    function automatic colour_e next_colour(input colour_e c);
        case (c)
            COL_R:   return COL_G;
            COL_G:   return COL_B;
            default: return COL_R;
        endcase
    endfunction

endpackage

// File: rtl/scan_par_port.sv
module scan_par_port
    import scan_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             strb_n,
    input  logic             rnw,
    input  logic             dna,
    input  logic [CFG_W-1:0] din,
    output wr_req_t          wr,
    output logic [CFG_W-1:0] ptr
);

    logic strb_d;
    logic wr_edge;

    assign wr_edge = active && strb_d && !strb_n && !rnw;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_d <= 1'b1;
            wr     <= '0;
            ptr    <= '0;
        end else begin
            strb_d  <= strb_n;
            wr.vld  <= wr_edge && dna;
            wr.addr <= ptr;
            wr.data <= din;
            if (wr_edge && !dna) begin
                ptr <= din;
            end
        end
    end

    // R2
    par_wr_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr.vld |-> ($past(active) && !$past(strb_n) && !$past(rnw)));

endmodule

// File: rtl/scan_ser_port.sv
module scan_ser_port
    import scan_host_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    sen,
    input  logic    sck,
    input  logic    sdi,
    output wr_req_t wr
);

    localparam int CNT_W = $clog2(SER_LEN + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SER_LEN);

    logic               sen_d;
    logic               sck_d;
    logic [SER_LEN-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               shift_en;
    logic               frame_end;

    assign shift_en  = active && sen && sck && !sck_d;
    assign frame_end = active && sen_d && !sen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sen_d <= 1'b0;
            sck_d <= 1'b1;
            shreg <= '0;
            cnt   <= '0;
            wr    <= '0;
        end else begin
            sen_d   <= sen;
            sck_d   <= sck;
            wr.vld  <= frame_end && (cnt == CNT_FULL);
            wr.addr <= shreg[SER_LEN-1 -: CFG_W];
            wr.data <= shreg[CFG_W-1:0];
            if (!sen) begin
                cnt <= '0;
            end else if (shift_en) begin
                shreg <= {shreg[SER_LEN-2:0], sdi};
                if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4
    ser_commit_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        wr.vld |-> ($past(sen_d) && !$past(sen) && $past(active)));

endmodule

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs
    import scan_host_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  wr_req_t                          wr,
    input  logic [CFG_W-1:0]                 rd_addr,
    output logic [CFG_W-1:0]                 rd_data,
    output logic [NUM_COL-1:0][GAIN_W-1:0]   gain,
    output logic [NUM_COL-1:0][OFF_W-1:0]    offs,
    output logic                             auto_cyc
);

    logic mapped_wr;

    for (genvar c = 0; c < NUM_COL; c++) begin : g_col
        logic [GAIN_W-1:0] gain_r;
        logic [OFF_W-1:0]  offs_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                gain_r <= '0;
                offs_r <= '0;
            end else if (wr.vld) begin
                if (wr.addr == GAIN_BASE + CFG_W'(c)) begin
                    gain_r <= wr.data[GAIN_W-1:0];
                end
                if (wr.addr == OFFS_BASE + CFG_W'(c)) begin
                    offs_r <= wr.data[OFF_W-1:0];
                end
            end
        end

        assign gain[c] = gain_r;
        assign offs[c] = offs_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_cyc <= 1'b0;
        end else if (wr.vld && wr.addr == CTRL_ADDR) begin
            auto_cyc <= wr.data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_COL; c++) begin
            if (rd_addr == GAIN_BASE + CFG_W'(c)) rd_data = CFG_W'(gain[c]);
            if (rd_addr == OFFS_BASE + CFG_W'(c)) rd_data = CFG_W'(offs[c]);
        end
        if (rd_addr == CTRL_ADDR) rd_data = CFG_W'(auto_cyc);
    end

    always_comb begin
        mapped_wr = (wr.addr == CTRL_ADDR);
        for (int c = 0; c < NUM_COL; c++) begin
            if (wr.addr == GAIN_BASE + CFG_W'(c) || wr.addr == OFFS_BASE + CFG_W'(c)) mapped_wr = 1'b1;
        end
    end

    // R6
    unmapped_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.vld && !mapped_wr) |=> ($stable(gain) && $stable(offs) && $stable(auto_cyc)));

endmodule

// File: rtl/scan_colour_ctl.sv
module scan_colour_ctl
    import scan_host_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sel0,
    input  logic    sel1,
    input  logic    auto_cyc,
    output colour_e colour,
    output colour_e tag
);

    localparam int AGE_W = $clog2(LAT + 1) + 1;

    logic                sel0_d;
    logic [LAT-1:0][1:0] pipe;
    logic [AGE_W-1:0]    age;

    always_ff @(posedge clk) begin
        sel0_d <= sel0;
        if (rst) begin
            colour <= COL_R;
        end else if (auto_cyc) begin
            if (sel0 && !sel0_d) begin
                colour <= next_colour(colour);
            end
        end else begin
            colour <= decode_sel(sel1, sel0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= colour;
            for (int i = 1; i < LAT; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign tag = colour_e'(pipe[LAT-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != AGE_W'(LAT)) begin
            age <= age + 1'b1;
        end
    end

    // R7
    colour_legal_chk: assert property (@(posedge clk) disable iff (rst)
        colour != 2'd3);

    // R8
    auto_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_cyc && !sel0) |=> $stable(colour));

    // R10
    tag_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_W'(LAT)) |-> (tag == $past(colour, 4)));

endmodule

// File: rtl/scan_host_ctrl.sv
module scan_host_ctrl
    import scan_host_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int TAG_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_sen,
    input  logic              rnw_sck,
    input  logic              dna_sdi,
    input  logic [CFG_W-1:0]  bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    input  logic              oe_n,
    input  logic              sel0_line,
    input  logic              sel1,
    input  logic [DATA_W-1:0] adc_data,
    output logic [1:0]        colour_sel,
    output logic [1:0]        colour_tag,
    output logic [GAIN_W-1:0] gain_cur,
    output logic [OFF_W-1:0]  offset_cur
);

    localparam int LOW_W = DATA_W - CFG_W;

    logic                           par_mode;
    wr_req_t                        par_wr;
    wr_req_t                        ser_wr;
    wr_req_t                        wr_mux;
    logic [CFG_W-1:0]               ptr;
    logic [CFG_W-1:0]               rd_data;
    logic [CFG_W-1:0]               rd_val;
    logic                           rd_active;
    logic [NUM_COL-1:0][GAIN_W-1:0] gain;
    logic [NUM_COL-1:0][OFF_W-1:0]  offs;
    logic                           auto_cyc;
    colour_e                        colour;
    colour_e                        tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_mode <= strb_sen;
        end
    end

    scan_par_port u_par (
        .clk    (clk),
        .rst    (rst),
        .active (par_mode),
        .strb_n (strb_sen),
        .rnw    (rnw_sck),
        .dna    (dna_sdi),
        .din    (bus_in),
        .wr     (par_wr),
        .ptr    (ptr)
    );

    scan_ser_port u_ser (
        .clk    (clk),
        .rst    (rst),
        .active (!par_mode),
        .sen    (strb_sen),
        .sck    (rnw_sck),
        .sdi    (dna_sdi),
        .wr     (ser_wr)
    );

    assign wr_mux = par_wr.vld ? par_wr : ser_wr;

    scan_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_mux),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .gain     (gain),
        .offs     (offs),
        .auto_cyc (auto_cyc)
    );

    scan_colour_ctl #(.LAT(TAG_LAT)) u_col (
        .clk      (clk),
        .rst      (rst),
        .sel0     (sel0_line),
        .sel1     (sel1),
        .auto_cyc (auto_cyc),
        .colour   (colour),
        .tag      (tag)
    );

    assign rd_active = par_mode && !strb_sen && rnw_sck;
    assign rd_val    = dna_sdi ? rd_data : ptr;

    always_comb begin
        if (rd_active) begin
            bus_out = {rd_val, {LOW_W{1'b0}}};
            bus_oe  = '1;
        end else begin
            bus_out = adc_data;
            bus_oe  = oe_n ? '0 : '1;
        end
    end

    always_comb begin
        case (colour)
            COL_G:   begin gain_cur = gain[1]; offset_cur = offs[1]; end
            COL_B:   begin gain_cur = gain[2]; offset_cur = offs[2]; end
            default: begin gain_cur = gain[0]; offset_cur = offs[0]; end
        endcase
    end

    assign colour_sel = colour;
    assign colour_tag = tag;

    // R3
    par_read_drives_chk: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> (bus_oe == '1 && bus_out[LOW_W-1:0] == '0));

    // R5
    ser_no_cfg_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_mode && oe_n) |-> (bus_oe == '0));

    // R11
    adc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_active && !oe_n) |-> (bus_out == adc_data));

endmodule

// File: tb/tb_scan_host_ctrl.sv
module tb_scan_host_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strb_sen = 1'b1;
    logic       rnw_sck = 1'b0;
    logic       dna_sdi = 1'b0;
    logic [7:0] bus_in = '0;
    logic [9:0] bus_out;
    logic [9:0] bus_oe;
    logic       oe_n = 1'b1;
    logic       sel0_line = 1'b0;
    logic       sel1 = 1'b0;
    logic [9:0] adc_data = '0;
    logic [1:0] colour_sel;
    logic [1:0] colour_tag;
    logic [5:0] gain_cur;
    logic [7:0] offset_cur;

    int n_chk = 0;
    int n_fail = 0;
    logic [5:0] m_gain [3];
    logic [7:0] m_off  [3];

    always #5 clk = ~clk;

    scan_host_ctrl dut (
        .clk(clk), .rst(rst), .strb_sen(strb_sen), .rnw_sck(rnw_sck), .dna_sdi(dna_sdi),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .oe_n(oe_n),
        .sel0_line(sel0_line), .sel1(sel1), .adc_data(adc_data),
        .colour_sel(colour_sel), .colour_tag(colour_tag),
        .gain_cur(gain_cur), .offset_cur(offset_cur)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [1:0] exp_dec(input logic s1, input logic s0);
        case ({s1, s0})
            2'b01:   return 2'd1;
            2'b10:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic actl);
        case (a)
            8'h00, 8'h01, 8'h02: return {2'b00, m_gain[a[1:0]]};
            8'h04, 8'h05, 8'h06: return m_off[a[1:0]];
            8'h08:               return {7'd0, actl};
            default:             return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h00, 8'h01, 8'h02: m_gain[a[1:0]] = d[5:0];
            8'h04, 8'h05, 8'h06: m_off[a[1:0]]  = d;
            default: ;
        endcase
    endfunction

    task automatic do_reset(input logic par);
        @(negedge clk);
        rst = 1'b1; strb_sen = par; rnw_sck = 1'b0; dna_sdi = 1'b0;
        sel0_line = 1'b0; sel1 = 1'b0; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 3; c++) begin m_gain[c] = '0; m_off[c] = '0; end
        @(negedge clk);
    endtask

    task automatic par_write(input logic da, input logic [7:0] v);
        @(negedge clk);
        rnw_sck = 1'b0; dna_sdi = da; bus_in = v; strb_sen = 1'b0;
        repeat (2) @(negedge clk);
        strb_sen = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic par_read(input logic da, output logic [7:0] v, output logic [9:0] oe, output logic [1:0] low);
        @(negedge clk);
        rnw_sck = 1'b1; dna_sdi = da; strb_sen = 1'b0;
        #2;
        v = bus_out[9:2]; oe = bus_oe; low = bus_out[1:0];
        @(negedge clk);
        strb_sen = 1'b1; rnw_sck = 1'b0;
    endtask

    task automatic ser_frame(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [15:0] w;
        w = {a, d};
        @(negedge clk);
        strb_sen = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            dna_sdi = w[15-i]; rnw_sck = 1'b0;
            @(negedge clk);
            rnw_sck = 1'b1;
            @(negedge clk);
        end
        rnw_sck = 1'b0;
        @(negedge clk);
        strb_sen = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_colour(input logic s1, input logic s0, input string tagn);
        logic [1:0] e;
        @(negedge clk);
        sel1 = s1; sel0_line = s0;
        @(negedge clk);
        #1;
        e = exp_dec(s1, s0);
        chk(colour_sel == e, {"R7 ", tagn}, colour_sel, e);
        chk(gain_cur == m_gain[e] && offset_cur == m_off[e], {"R9 ", tagn},
            {gain_cur, offset_cur}, {m_gain[e], m_off[e]});
    endtask

    task automatic check_tag(input int cycles);
        logic [1:0] hist [64];
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1;
            hist[i] = colour_sel;
            if (i >= 4) chk(colour_tag == hist[i-4], "R10 tag delay", colour_tag, hist[i-4]);
            sel0_line = 1'($urandom); sel1 = 1'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        logic [9:0] roe;
        logic [1:0] rlow;
        logic [7:0] addrs [9];
        logic [1:0] ecol;
        void'($urandom(32'h5CA77E));
        addrs = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h03, 8'h0F, 8'h80};

        // ---- parallel mode ----
        do_reset(1'b1);
        #1;
        chk(colour_sel == 2'd0 && colour_tag == 2'd0, "R7 reset colour red", colour_sel, 0);
        chk(bus_oe == '0, "R11 idle bus released", bus_oe, 0);
        par_write(1'b0, 8'h01);
        par_read(1'b1, rv, roe, rlow);
        chk(rv == 8'h00, "R6 reset gain value", rv, 0);
        chk(roe == 10'h3FF && rlow == 2'b00, "R3 read drives bus", {roe, rlow}, {10'h3FF, 2'b00});

        for (int k = 0; k < 30; k++) begin
            logic [7:0] a, d;
            a = addrs[$urandom_range(0, 8)];
            d = 8'($urandom);
            par_write(1'b0, a);
            par_read(1'b0, rv, roe, rlow);
            chk(rv == a, "R3 pointer readback", rv, a);
            par_write(1'b1, d);
            model_write(a, d);
            par_read(1'b1, rv, roe, rlow);
            chk(rv == exp_read(a, 1'b0), "R2 R6 write then read", rv, exp_read(a, 1'b0));
        end

        for (int k = 0; k < 12; k++) check_colour(1'($urandom), 1'($urandom), "manual select");
        check_colour(1'b1, 1'b1, "code 11 gives red");

        // conversion bus
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            adc_data = 10'($urandom); oe_n = 1'b0;
            #2;
            chk(bus_out == adc_data && bus_oe == 10'h3FF, "R11 conversion on bus", bus_out, adc_data);
        end
        @(negedge clk);
        oe_n = 1'b1;
        #2;
        chk(bus_oe == '0, "R11 oe_n high releases bus", bus_oe, 0);

        check_tag(40);

        // auto-cycle
        check_colour(1'b0, 1'b0, "before auto");
        par_write(1'b0, 8'h08);
        par_write(1'b1, 8'h01);
        par_read(1'b1, rv, roe, rlow);
        chk(rv == 8'h01, "R6 control readback", rv, 1);
        ecol = 2'd0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            sel0_line = 1'b1; sel1 = 1'($urandom);
            @(negedge clk);
            #1;
            ecol = (ecol == 2'd2) ? 2'd0 : ecol + 2'd1;
            chk(colour_sel == ecol, "R8 line-start step", colour_sel, ecol);
            sel1 = ~sel1;
            repeat (2) @(negedge clk);
            #1;
            chk(colour_sel == ecol, "R8 held high and sel1 ignored", colour_sel, ecol);
            sel0_line = 1'b0;
            @(negedge clk);
        end

        // ---- serial mode ----
        do_reset(1'b0);
        #1;
        chk(colour_sel == 2'd0, "R1 reset into serial", colour_sel, 0);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] a, d;
            a = addrs[$urandom_range(0, 8)];
            d = 8'($urandom);
            ser_frame(a, d, 16);
            model_write(a, d);
        end
        for (int c = 0; c < 3; c++) check_colour(c == 2, c == 1, "serial written regs");
        ser_frame(8'h00, 8'h2A, 16);
        model_write(8'h00, 8'h2A);
        ser_frame(8'h00, 8'h15, 15);
        ser_frame(8'h00, 8'h15, 17);
        check_colour(1'b0, 1'b0, "R4 short and long frames dropped");
        chk(gain_cur == 6'h2A, "R4 full frame kept", gain_cur, 6'h2A);

        @(negedge clk);
        strb_sen = 1'b0; rnw_sck = 1'b1; dna_sdi = 1'b1; oe_n = 1'b1;
        #2;
        chk(bus_oe == '0, "R5 no config drive in serial mode", bus_oe, 0);
        chk(bus_oe == '0, "R1 serial mode holds after reset", bus_oe, 0);
        @(negedge clk);
        rnw_sck = 1'b0;

        finish_run();
    end

endmodule